// File: doc/BRIEF.md
# Multi-Width SPI NAND Transfer Engine

This block moves short bursts between a host register bus and a serial NAND flash. Each burst is one to four bytes on a serial bus one, two or four data lanes wide. Software builds a flash operation from several bursts while the device stays selected: opcode, address, dummy clocks and data. It sets up a transmit burst by writing a command word and then the data word that starts it. It starts a receive burst by writing a receive-command word, and it collects the result from a data register once the busy flag drops.

The serial clock runs at a fixed fraction of the system clock. It is low when idle, and data is sampled on its rising edge. The chip selects are active low and are under direct software control, so one device can stay selected across any number of bursts. The IO lanes are brought out as separate output, output-enable and input vectors, for a pad ring to combine.

Top module: `snand_pio`

## Requirements
- R1: After reset, both chip selects are high, the serial clock is low, all output enables are low, and the status and received-data registers read zero.
- R2: The chip-select register is at offset 0x04 and resets to all ones. Its bit 4·k drives the active-low select of device k (bit 0 for device 0, bit 4 for device 1). A select keeps its value across bursts and changes only on a write to this register.
- R3: Command word fields: bits 1:0 hold the byte count minus one, and bits 29:28 hold the lane code (0 = one lane, 1 = two, 2 = four, 3 = one). A burst gives exactly 8·bytes/lanes rising clock edges. The transmit command sits at 0x08 and reads back its stored fields in the same positions.
- R4: A write to offset 0x14 while idle starts a transmit burst that uses the stored transmit command. Data leaves most significant bit first, from bit 31. With one lane the data goes out on IO0. With two lanes IO1 carries the higher bit of each pair. With four lanes IO3 carries the highest bit of each nibble. Output enables are high on exactly the used lanes.
- R5: A write to offset 0x0C while idle starts a receive burst. With one lane the data comes in on IO1; with two lanes, IO1 is the higher bit of each pair. The first byte received lands in bits 7:0 and later bytes fill higher lanes in order. Unused upper bytes read zero at offset 0x10. No output enable is raised.
- R6: Status bit 3 at offset 0x40 is high from the edge that starts a burst until the burst ends; every other status bit reads zero.
- R7: The serial clock idles low and has a period of 2·DIV system clocks, one rising edge per shifted bit group.
- R8: When bit 31 of the transmit command is set, the burst makes only clock edges and keeps every output enable low.
- R9: Writes to 0x08, 0x0C and 0x14 made while busy have no effect: no burst starts and the stored transmit command is kept.
- R10: The received-data register keeps its value until the next receive burst ends; transmit bursts do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | AW | Register byte offset |
| bus_we_i | input | 1 | Register write strobe, one cycle |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | NCS | Active-low device selects |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |

## Verification
A wrong lane decode or shift step shows up as a wrong bit within the first serial clock of a burst. It can be seen at the rising edge, on either io_o or io_oe_o. A bad edge counter shows as too few or too many rising edges by the time the busy flag drops, which is a few hundred system clocks at most. Receive packing errors are only visible after the burst ends, when offset 0x10 is read back. Select or busy-gating faults show as a select changing during a burst, or as extra edges after writes that should have been ignored.

// File: rtl/snand_pkg.sv
package snand_pkg;
  localparam int unsigned OFF_CS   = 'h04;
  localparam int unsigned OFF_WCMD = 'h08;
  localparam int unsigned OFF_RCMD = 'h0C;
  localparam int unsigned OFF_RDAT = 'h10;
  localparam int unsigned OFF_WDAT = 'h14;
  localparam int unsigned OFF_STAT = 'h40;

  typedef struct packed {
    logic       dummy;
    logic [1:0] wid;
    logic [1:0] len;
  } burst_cfg_t;

  function automatic logic [5:0] clocks_of(burst_cfg_t c);
    logic [5:0] bits;
    bits = 6'(({4'b0, c.len} + 6'd1) << 3);
    case (c.wid)
      2'd1:    return bits >> 1;
      2'd2:    return bits >> 2;
      default: return bits;
    endcase
  endfunction

  // first received byte goes to lane 0
  function automatic logic [31:0] pack_le(logic [31:0] rx, logic [1:0] len);
    logic [31:0] o;
    o = '0;
    for (int k = 0; k < 4; k++)
      if (k <= int'(len)) o[8*k +: 8] = 8'(rx >> (8 * (int'(len) - k)));
    return o;
  endfunction
endpackage

// File: rtl/snand_regs.sv
module snand_regs
  import snand_pkg::*;
#(
  parameter int unsigned AW  = 7,
  parameter int unsigned NCS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_we_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic          busy_i,
  input  logic [31:0]   rx_word_i,
  output logic          tx_start_o,
  output logic          rx_start_o,
  output burst_cfg_t    cfg_o,
  output logic [31:0]   tx_word_o,
  output logic [NCS-1:0] cs_n_o
);
  logic [NCS-1:0] cs_q;
  burst_cfg_t     wcfg_q, rcfg_q, rcfg_d;
  logic           hit_cs, hit_wcmd;
  logic [31:0]    cs_word;

  assign hit_cs     = bus_we_i && bus_addr_i == AW'(OFF_CS);
  assign hit_wcmd   = bus_we_i && bus_addr_i == AW'(OFF_WCMD);
  assign tx_start_o = bus_we_i && bus_addr_i == AW'(OFF_WDAT) && !busy_i;
  assign rx_start_o = bus_we_i && bus_addr_i == AW'(OFF_RCMD) && !busy_i;
  assign rcfg_d     = '{dummy: 1'b0, wid: bus_wdata_i[29:28], len: bus_wdata_i[1:0]};
  assign cfg_o      = rx_start_o ? rcfg_d : wcfg_q;
  assign tx_word_o  = bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '1;
      wcfg_q <= '0;
      rcfg_q <= '0;
    end else begin
      if (hit_cs) cs_q <= cs_word_sel(bus_wdata_i);
      if (hit_wcmd && !busy_i)
        wcfg_q <= '{dummy: bus_wdata_i[31], wid: bus_wdata_i[29:28], len: bus_wdata_i[1:0]};
      if (rx_start_o) rcfg_q <= rcfg_d;
    end
  end

  function automatic logic [NCS-1:0] cs_word_sel(logic [31:0] w);
    logic [NCS-1:0] s;
    for (int k = 0; k < NCS; k++) s[k] = w[4*k];
    return s;
  endfunction

  always_comb begin
    cs_word = '1;
    for (int k = 0; k < NCS; k++) cs_word[4*k] = cs_q[k];
  end

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_n_o[k] = cs_q[k];
  end

  always_comb begin
    case (bus_addr_i)
      AW'(OFF_CS):   bus_rdata_o = cs_word;
      AW'(OFF_WCMD): bus_rdata_o = {wcfg_q.dummy, 1'b0, wcfg_q.wid, 26'b0, wcfg_q.len};
      AW'(OFF_RCMD): bus_rdata_o = {2'b0, rcfg_q.wid, 26'b0, rcfg_q.len};
      AW'(OFF_RDAT): bus_rdata_o = rx_word_i;
      AW'(OFF_STAT): bus_rdata_o = {28'b0, busy_i, 3'b0};
      default:       bus_rdata_o = '0;
    endcase
  end

  // R9: stored transmit command survives writes made while busy
  p_wcmd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && hit_wcmd |=> $stable(wcfg_q));
  // R2: selects move only on a chip-select write
  p_cs_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_cs |=> $stable(cs_n_o));
endmodule

// File: rtl/snand_shift.sv
module snand_shift
  import snand_pkg::*;
#(
  parameter int unsigned DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_start_i,
  input  logic        rx_start_i,
  input  burst_cfg_t  cfg_i,
  input  logic [31:0] tx_word_i,
  output logic        busy_o,
  output logic [31:0] rx_word_o,
  output logic        sclk_o,
  output logic [3:0]  io_o,
  output logic [3:0]  io_oe_o,
  input  logic [3:0]  io_i
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          busy_q, sclk_q, is_rx_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]    left_q;
  logic [31:0]   sh_q, rx_q, rx_nxt, sh_nxt, rdata_q;
  burst_cfg_t    cfg_q;
  logic [3:0]    lane_mask;

  always_comb begin
    case (cfg_q.wid)
      2'd1: begin
        io_o = {2'b0, sh_q[31:30]}; lane_mask = 4'b0011;
        sh_nxt = sh_q << 2; rx_nxt = {rx_q[29:0], io_i[1:0]};
      end
      2'd2: begin
        io_o = sh_q[31:28]; lane_mask = 4'b1111;
        sh_nxt = sh_q << 4; rx_nxt = {rx_q[27:0], io_i};
      end
      default: begin
        io_o = {3'b0, sh_q[31]}; lane_mask = 4'b0001;
        sh_nxt = sh_q << 1; rx_nxt = {rx_q[30:0], io_i[1]};
      end
    endcase
  end

  assign io_oe_o   = (busy_q && !is_rx_q && !cfg_q.dummy) ? lane_mask : 4'b0;
  assign busy_o    = busy_q;
  assign sclk_o    = sclk_q;
  assign rx_word_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      is_rx_q <= 1'b0;
      cnt_q   <= '0;
      left_q  <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      cfg_q   <= '0;
    end else if (!busy_q) begin
      if (tx_start_i || rx_start_i) begin
        busy_q  <= 1'b1;
        is_rx_q <= rx_start_i;
        cfg_q   <= cfg_i;
        sh_q    <= tx_word_i;
        rx_q    <= '0;
        left_q  <= clocks_of(cfg_i);
        cnt_q   <= '0;
        sclk_q  <= 1'b0;
      end
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        if (is_rx_q) rx_q <= rx_nxt;
      end else begin
        sclk_q <= 1'b0;
        sh_q   <= sh_nxt;
        left_q <= left_q - 6'd1;
        if (left_q == 6'd1) begin
          busy_q <= 1'b0;
          if (is_rx_q) rdata_q <= pack_le(rx_q, cfg_q.len);
        end
      end
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R7: clock rests low outside a burst
  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  // R7: clock edges only at the end of a divider period
  p_edge_pace_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_q) |-> $past(cnt_q) == CW'(DIV - 1));
  // R5: receive never drives the lanes
  p_rx_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && is_rx_q |-> io_oe_o == 4'b0);
  // R8: dummy bursts never drive the lanes
  p_dummy_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cfg_q.dummy |-> io_oe_o == 4'b0);
  // R6: busy rises only from a start request
  p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(tx_start_i || rx_start_i));
endmodule

// File: rtl/snand_pio.sv
module snand_pio
  import snand_pkg::*;
#(
  parameter int unsigned AW  = 7,
  parameter int unsigned DIV = 2,
  parameter int unsigned NCS = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic           bus_we_i,
  input  logic [31:0]    bus_wdata_i,
  output logic [31:0]    bus_rdata_o,
  output logic           sclk_o,
  output logic [NCS-1:0] cs_n_o,
  output logic [3:0]     io_o,
  output logic [3:0]     io_oe_o,
  input  logic [3:0]     io_i
);
  logic        busy, tx_start, rx_start;
  logic [31:0] rx_word, tx_word;
  burst_cfg_t  cfg;

  snand_regs #(.AW(AW), .NCS(NCS)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .busy_i(busy), .rx_word_i(rx_word),
    .tx_start_o(tx_start), .rx_start_o(rx_start),
    .cfg_o(cfg), .tx_word_o(tx_word), .cs_n_o(cs_n_o)
  );

  snand_shift #(.DIV(DIV)) shift_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_start_i(tx_start), .rx_start_i(rx_start),
    .cfg_i(cfg), .tx_word_i(tx_word),
    .busy_o(busy), .rx_word_o(rx_word),
    .sclk_o(sclk_o), .io_o(io_o), .io_oe_o(io_oe_o), .io_i(io_i)
  );
endmodule

// File: tb/snand_pio_tb_top.sv
`timescale 1ns/1ps
module snand_pio_tb_top;
  localparam int DIV = 2;
  localparam int AW  = 7;
  localparam logic [6:0] A_CS = 7'h04, A_WCMD = 7'h08, A_RCMD = 7'h0C,
                         A_RDAT = 7'h10, A_WDAT = 7'h14, A_STAT = 7'h40;

  // {rx, dummy, wid[1:0], len[1:0], data[31:0]}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 1'b0, 2'd0, 2'd3, 32'hA5C30F96},
    {1'b0, 1'b0, 2'd1, 2'd3, 32'h12345678},
    {1'b0, 1'b0, 2'd2, 2'd1, 32'h9ABCDEF0},
    {1'b0, 1'b0, 2'd0, 2'd0, 32'h0F000000},
    {1'b1, 1'b0, 2'd0, 2'd3, 32'hDEADBEEF},
    {1'b1, 1'b0, 2'd1, 2'd1, 32'hC3A50000},
    {1'b1, 1'b0, 2'd2, 2'd3, 32'h01234567},
    {1'b1, 1'b0, 2'd2, 2'd0, 32'h7E000000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic sclk;
  logic [1:0] cs_n;
  logic [3:0] io_o, io_oe, io_i;

  int total = 0, bad = 0;
  logic [31:0] cap, src;
  int nedge, idx, lanes = 1, oe_bad, cs_bad = 0, per_bad;
  logic [3:0] exp_oe = 4'b0;
  logic [1:0] exp_cs = 2'b11;
  time last_t;

  always #4 clk = ~clk;

  snand_pio #(.AW(AW), .DIV(DIV), .NCS(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sclk_o(sclk), .cs_n_o(cs_n),
    .io_o(io_o), .io_oe_o(io_oe), .io_i(io_i)
  );

  // flash-side model
  always @(posedge sclk) begin
    case (lanes)
      2:       cap = {cap[29:0], io_o[1:0]};
      4:       cap = {cap[27:0], io_o};
      default: cap = {cap[30:0], io_o[0]};
    endcase
    if (io_oe !== exp_oe) oe_bad++;
    if (cs_n !== exp_cs) cs_bad++;
    if (nedge > 0 && ($time - last_t) != 2 * DIV * 8) per_bad++;
    last_t = $time;
    nedge++;
  end
  always @(negedge sclk) idx++;

  always_comb begin
    logic [31:0] s;
    s = src << (idx * lanes);
    case (lanes)
      2:       io_i = {2'b0, s[31:30]};
      4:       io_i = s[31:28];
      default: io_i = {2'b0, s[31], 1'b0};
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, s);
      if (!s[3]) break;
    end
  endtask

  task automatic arm(input int l, input logic [31:0] s, input logic [3:0] oe);
    cap = '0; nedge = 0; idx = 0; lanes = l; src = s; exp_oe = oe;
    oe_bad = 0; per_bad = 0;
  endtask

  function automatic int lanes_of(input logic [1:0] w);
    return (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] mask_of(input int l);
    return (l == 4) ? 4'b1111 : (l == 2) ? 4'b0011 : 4'b0001;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, e, last_rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 2'b11, "R1 cs_n", 32'(cs_n), 32'h3);
    chk(sclk == 1'b0 && io_oe == 4'b0, "R1 sclk/oe", {27'b0, sclk, io_oe}, 32'h0);
    rd(A_STAT, r); chk(r == 32'h0, "R1 status", r, 32'h0);
    rd(A_RDAT, r); chk(r == 32'h0, "R1 rdata", r, 32'h0);

    // R2 select device 0
    wr(A_CS, ~32'h1); exp_cs = 2'b10;
    @(negedge clk); chk(cs_n == 2'b10, "R2 cs0", 32'(cs_n), 32'h2);

    last_rx = '0;
    for (int i = 0; i < 8; i++) begin
      logic [37:0] v;
      int l, nb;
      logic [31:0] cmd;
      v = VEC[i];
      l = lanes_of(v[35:34]);
      nb = int'(v[33:32]) + 1;
      cmd = {v[36], 1'b0, v[35:34], 26'b0, v[33:32]};
      if (v[37]) begin
        arm(l, v[31:0], 4'b0);
        wr(A_RCMD, cmd);
      end else begin
        arm(l, 32'h0, mask_of(l));
        wr(A_WCMD, cmd);
        wr(A_WDAT, v[31:0]);
      end
      wait_idle();
      chk(nedge == nb * 8 / l, "R3 clock count", 32'(nedge), 32'(nb * 8 / l));
      chk(per_bad == 0, "R7 sclk period", 32'(per_bad), 32'h0);
      if (v[37]) begin
        e = '0;
        for (int k = 0; k < nb; k++) e[8*k +: 8] = v[31 - 8*k -: 8];
        rd(A_RDAT, r); chk(r == e, "R5 rx packing", r, e);
        chk(oe_bad == 0, "R5 no drive", 32'(oe_bad), 32'h0);
        last_rx = e;
      end else begin
        e = v[31:0] >> (32 - 8 * nb);
        chk(cap == e, "R4 tx bits", cap, e);
        chk(oe_bad == 0, "R4 lane enables", 32'(oe_bad), 32'h0);
      end
    end
    chk(cs_bad == 0, "R2 cs held across bursts", 32'(cs_bad), 32'h0);

    // R6 busy flag
    arm(1, 32'h0, 4'b0001);
    wr(A_WCMD, 32'h0000_0003);
    wr(A_WDAT, 32'hFFFF_FFFF);
    rd(A_STAT, r); chk(r == 32'h8, "R6 busy high", r, 32'h8);
    // R9 writes while busy ignored
    wr(A_WCMD, 32'h2000_0000);
    wr(A_WDAT, 32'h0);
    wr(A_RCMD, 32'h2000_0003);
    wait_idle();
    rd(A_STAT, r); chk(r == 32'h0, "R6 busy low", r, 32'h0);
    chk(nedge == 32, "R9 no extra burst", 32'(nedge), 32'd32);
    chk(cap == 32'hFFFF_FFFF, "R9 data kept", cap, 32'hFFFF_FFFF);
    rd(A_WCMD, r); chk(r == 32'h3, "R9 wcmd kept", r, 32'h3);
    rd(A_RDAT, r); chk(r == last_rx, "R10 rdata after tx", r, last_rx);
    arm(1, 32'h0, 4'b0001);
    wr(A_WDAT, 32'h5A00_0000);
    wait_idle();
    chk(nedge == 32 && cap == 32'h5A00_0000, "R9 old cmd used", cap, 32'h5A00_0000);

    // R8 dummy burst
    arm(1, 32'h0, 4'b0000);
    wr(A_WCMD, 32'h8000_0001);
    wr(A_WDAT, 32'hFFFF_FFFF);
    wait_idle();
    chk(nedge == 16, "R8 dummy clocks", 32'(nedge), 32'd16);
    chk(oe_bad == 0, "R8 dummy no drive", 32'(oe_bad), 32'h0);
    rd(A_RDAT, r); chk(r == last_rx, "R10 rdata after dummy", r, last_rx);

    // R2 device 1 and release
    wr(A_CS, ~32'h10); exp_cs = 2'b01;
    @(negedge clk); chk(cs_n == 2'b01, "R2 cs1", 32'(cs_n), 32'h1);
    rd(A_CS, r); chk(r == ~32'h10, "R2 cs readback", r, ~32'h10);
    wr(A_CS, 32'hFFFF_FFFF); exp_cs = 2'b11;
    @(negedge clk); chk(cs_n == 2'b11, "R2 release", 32'(cs_n), 32'h3);
    chk(sclk == 1'b0 && io_oe == 4'b0, "R7 idle low", {27'b0, sclk, io_oe}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule